// File: doc/BRIEF.md
# Write-Once Block Location Directory

This block is a small associative table that turns a prefix hash of a token sequence into the base address of a large key/value block. Every entry is compared against the request at once, so a hit returns the stored address one clock after the request. No table walk is involved. A lookup must match three things on the entry: the hash, the model version, and the session partition.

Each entry follows a one-way life cycle. An allocate request claims an entry and puts it in the WRITING state, where its producer owns it and no lookup can see it. A completion hint, addressed by the entry index the allocate returned, moves the entry to SHARED. A SHARED entry is read-only and is never tracked or modified again until it is reclaimed. An entry whose model version differs from that of a new allocate request counts as stale, and that allocate may reclaim it when no free entry remains. The engine uses the allocate response to learn where to write, sends the hint when the data is complete, and uses lookups to skip recomputation of cached prefixes.

Top module: `kvd_directory`

## Requirements
- R1: A lookup whose hash, model version and partition all match a SHARED entry raises `lkp_hit` with that entry's base address on `lkp_base` in the cycle after the request. Otherwise it raises `lkp_miss` in that cycle.
- R2: A lookup never hits an entry that is in the WRITING state.
- R3: A completion hint on a WRITING entry makes it SHARED at the next edge. A lookup presented in the cycle after the hint hits, and a lookup presented in the same cycle as the hint does not.
- R4: Once an entry is SHARED, its hash, version, partition, address and state stay as they are until an allocate reclaims the entry.
- R5: A lookup whose model version differs from the stored version misses.
- R6: A lookup whose partition differs from the stored partition misses.
- R7: An allocate that is not a duplicate takes the lowest-numbered FREE entry. In the next cycle it answers with `alloc_ok` and the entry index on `alloc_idx`.
- R8: When no entry is FREE, an allocate reclaims the lowest-numbered entry whose stored model version differs from the request's version. The old contents of that entry stop hitting from the next cycle.
- R9: An allocate whose hash matches a WRITING or SHARED entry of the same model version answers with `alloc_dup`, in any partition, and leaves every entry unchanged.
- R10: An allocate that finds neither a FREE nor a stale entry answers with `alloc_full` and overwrites nothing.
- R11: A completion hint for an entry that is not WRITING, or for an index beyond the table, is ignored and raises a one-cycle `done_err` in the next cycle.
- R12: When an allocate and a lookup arrive in the same cycle, the lookup is answered from the table as it was before that allocate.
- R13: After reset every entry is FREE and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | Allocate request strobe |
| alloc_hash | input | HASH_W | Prefix hash of the new block |
| alloc_model | input | MODEL_W | Model version of the new block |
| alloc_part | input | PART_W | Session partition of the new block |
| alloc_base | input | ADDR_W | Physical base address of the new block |
| done_valid | input | 1 | Completion hint strobe |
| done_idx | input | IDX_W | Entry index the hint refers to |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_hash | input | HASH_W | Hash to search for |
| lkp_model | input | MODEL_W | Model version of the requester |
| lkp_part | input | PART_W | Session partition of the requester |
| alloc_ok | output | 1 | Allocate accepted |
| alloc_dup | output | 1 | Allocate rejected as a duplicate |
| alloc_full | output | 1 | Allocate rejected, no entry available |
| alloc_idx | output | IDX_W | Entry index given to an accepted allocate |
| done_err | output | 1 | Completion hint was illegal and was ignored |
| lkp_hit | output | 1 | Lookup found a readable block |
| lkp_miss | output | 1 | Lookup found no readable block |
| lkp_base | output | ADDR_W | Base address of the block found |

## Verification
The bench fills a four-entry table across two partitions and then sweeps every lookup combination of hash, model version and partition over it. This shows whether each of the three match fields is actually compared. Lookups made before, during and after completion hints separate a WRITING entry from a SHARED one. They also show the exact cycle at which a block becomes visible. Allocates against a full table are made with the same version, a new version and a repeated hash. These cases tell reclaim apart from the full and duplicate rejections, and show which index is chosen. One cycle combines a reclaiming allocate with a lookup of the block being displaced, so it shows whether the lookup is answered from the table as it was before the allocate.

// File: rtl/kvd_pkg.sv
package kvd_pkg;
  typedef enum logic [1:0] {
    KVD_FREE    = 2'd0,
    KVD_WRITING = 2'd1,
    KVD_SHARED  = 2'd2
  } kvd_state_e;
endpackage

// File: rtl/kvd_entry_cmp.sv
// Per-entry comparators: lookup hit, duplicate, stale and free qualifiers.
module kvd_entry_cmp
  import kvd_pkg::*;
#(
  parameter int HASH_W  = 32,
  parameter int MODEL_W = 8,
  parameter int PART_W  = 4
) (
  input  kvd_state_e         state,
  input  logic [HASH_W-1:0]  ent_hash,
  input  logic [MODEL_W-1:0] ent_model,
  input  logic [PART_W-1:0]  ent_part,
  input  logic [HASH_W-1:0]  lk_hash,
  input  logic [MODEL_W-1:0] lk_model,
  input  logic [PART_W-1:0]  lk_part,
  input  logic [HASH_W-1:0]  al_hash,
  input  logic [MODEL_W-1:0] al_model,
  output logic               lk_hit,
  output logic               al_dup,
  output logic               al_stale,
  output logic               al_free
);
  logic live;

  always_comb begin
    live     = (state != KVD_FREE);
    lk_hit   = (state == KVD_SHARED) && (ent_hash == lk_hash) &&
               (ent_model == lk_model) && (ent_part == lk_part);
    al_dup   = live && (ent_hash == al_hash) && (ent_model == al_model);
    al_stale = live && (ent_model != al_model);
    al_free  = !live;
  end
endmodule

// File: rtl/kvd_first_set.sv
// Lowest-index priority pick over a request vector.
module kvd_first_set #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/kvd_directory.sv
module kvd_directory
  import kvd_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int HASH_W  = 32,
  parameter int MODEL_W = 8,
  parameter int PART_W  = 4,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [HASH_W-1:0]  alloc_hash,
  input  logic [MODEL_W-1:0] alloc_model,
  input  logic [PART_W-1:0]  alloc_part,
  input  logic [ADDR_W-1:0]  alloc_base,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic               lkp_valid,
  input  logic [HASH_W-1:0]  lkp_hash,
  input  logic [MODEL_W-1:0] lkp_model,
  input  logic [PART_W-1:0]  lkp_part,
  output logic               alloc_ok,
  output logic               alloc_dup,
  output logic               alloc_full,
  output logic [IDX_W-1:0]   alloc_idx,
  output logic               done_err,
  output logic               lkp_hit,
  output logic               lkp_miss,
  output logic [ADDR_W-1:0]  lkp_base
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Entry storage
  kvd_state_e         state_q [ENTRIES];
  kvd_state_e         state_d [ENTRIES];
  logic [HASH_W-1:0]  hash_q  [ENTRIES];
  logic [MODEL_W-1:0] model_q [ENTRIES];
  logic [PART_W-1:0]  part_q  [ENTRIES];
  logic [ADDR_W-1:0]  base_q  [ENTRIES];

  logic [ENTRIES-1:0] hit_vec, dup_vec, stale_vec, free_vec, wr_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    kvd_entry_cmp #(.HASH_W(HASH_W), .MODEL_W(MODEL_W), .PART_W(PART_W)) u_cmp (
      .state    (state_q[g]),
      .ent_hash (hash_q[g]),
      .ent_model(model_q[g]),
      .ent_part (part_q[g]),
      .lk_hash  (lkp_hash),
      .lk_model (lkp_model),
      .lk_part  (lkp_part),
      .al_hash  (alloc_hash),
      .al_model (alloc_model),
      .lk_hit   (hit_vec[g]),
      .al_dup   (dup_vec[g]),
      .al_stale (stale_vec[g]),
      .al_free  (free_vec[g])
    );
  end

  logic             free_found, stale_found;
  logic [IDX_W-1:0] free_idx, stale_idx;

  kvd_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_free (
    .vec(free_vec), .found(free_found), .idx(free_idx)
  );
  kvd_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_stale (
    .vec(stale_vec), .found(stale_found), .idx(stale_idx)
  );

  // Allocate / done decisions
  logic             dup_any, alloc_take, alloc_nospace, done_legal, done_bad;
  logic [IDX_W-1:0] pick_idx;
  logic [ADDR_W-1:0] base_mux;

  always_comb begin
    dup_any       = |dup_vec;
    alloc_take    = alloc_valid && !dup_any && (free_found || stale_found);
    alloc_nospace = alloc_valid && !dup_any && !free_found && !stale_found;
    pick_idx      = free_found ? free_idx : stale_idx;
    done_legal    = 1'b0;
    if (int'(done_idx) < ENTRIES) done_legal = (state_q[done_idx] == KVD_WRITING);
    done_bad      = done_valid && !done_legal;
    for (int i = 0; i < ENTRIES; i++) wr_en[i] = alloc_take && (pick_idx == IDX_W'(i));
    base_mux = '0;
    for (int i = 0; i < ENTRIES; i++) base_mux |= hit_vec[i] ? base_q[i] : '0;
  end

  // Next state: hint applied first, a reclaiming allocate overrides it.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      state_d[i] = state_q[i];
      if (done_valid && done_legal && (done_idx == IDX_W'(i))) state_d[i] = KVD_SHARED;
      if (wr_en[i]) state_d[i] = KVD_WRITING;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) state_q[i] <= KVD_FREE;
    end else begin
      for (int i = 0; i < ENTRIES; i++) state_q[i] <= state_d[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en[i]) begin
        hash_q[i]  <= alloc_hash;
        model_q[i] <= alloc_model;
        part_q[i]  <= alloc_part;
        base_q[i]  <= alloc_base;
      end
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_ok   <= 1'b0;
      alloc_dup  <= 1'b0;
      alloc_full <= 1'b0;
      alloc_idx  <= '0;
      done_err   <= 1'b0;
      lkp_hit    <= 1'b0;
      lkp_miss   <= 1'b0;
      lkp_base   <= '0;
    end else begin
      alloc_ok   <= alloc_take;
      alloc_dup  <= alloc_valid && dup_any;
      alloc_full <= alloc_nospace;
      if (alloc_take) alloc_idx <= pick_idx;
      done_err   <= done_bad;
      lkp_hit    <= lkp_valid && (|hit_vec);
      lkp_miss   <= lkp_valid && !(|hit_vec);
      if (lkp_valid) lkp_base <= base_mux;
    end
  end

  // Assertions
  assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_hit_miss_excl_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !(lkp_hit && lkp_miss));

  assert_alloc_resp_excl_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({alloc_ok, alloc_dup, alloc_full}));

  assert_err_needs_hint_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    done_err |-> $past(done_valid));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    assert_writing_hidden_R2: assert property (@(posedge clk) disable iff (!rst_ni)
      (lkp_valid && state_q[g] == KVD_WRITING && hash_q[g] == lkp_hash &&
       model_q[g] == lkp_model && part_q[g] == lkp_part) |=> !lkp_hit);

    assert_hint_publishes_R3: assert property (@(posedge clk) disable iff (!rst_ni)
      (done_valid && done_idx == IDX_W'(g) && state_q[g] == KVD_WRITING && !wr_en[g])
      |=> state_q[g] == KVD_SHARED);

    assert_shared_frozen_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      (state_q[g] == KVD_SHARED && !wr_en[g]) |=>
      (state_q[g] == KVD_SHARED && $stable(base_q[g]) && $stable(hash_q[g]) &&
       $stable(model_q[g]) && $stable(part_q[g])));
  end
endmodule

// File: tb/kvd_directory_bench.sv
module kvd_directory_bench;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_valid, done_valid, lkp_valid;
  logic [7:0] alloc_hash, alloc_base, lkp_hash;
  logic [1:0] alloc_model, alloc_part, lkp_model, lkp_part, done_idx;
  logic       alloc_ok, alloc_dup, alloc_full, done_err, lkp_hit, lkp_miss;
  logic [1:0] alloc_idx;
  logic [7:0] lkp_base;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  kvd_directory #(.ENTRIES(N), .HASH_W(8), .MODEL_W(2), .PART_W(2), .ADDR_W(8)) u_kvd_directory (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_hash(alloc_hash), .alloc_model(alloc_model),
    .alloc_part(alloc_part), .alloc_base(alloc_base),
    .done_valid(done_valid), .done_idx(done_idx),
    .lkp_valid(lkp_valid), .lkp_hash(lkp_hash), .lkp_model(lkp_model), .lkp_part(lkp_part),
    .alloc_ok(alloc_ok), .alloc_dup(alloc_dup), .alloc_full(alloc_full), .alloc_idx(alloc_idx),
    .done_err(done_err), .lkp_hit(lkp_hit), .lkp_miss(lkp_miss), .lkp_base(lkp_base)
  );

  // Reference table: 0 free, 1 writing, 2 shared
  int         mst [N];
  logic [7:0] mh [N];
  logic [1:0] mm [N];
  logic [1:0] mp [N];
  logic [7:0] mb [N];

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit av, input logic [7:0] ah, input logic [1:0] am,
                      input logic [1:0] ap, input logic [7:0] ab,
                      input bit dv, input logic [1:0] di,
                      input bit lv, input logic [7:0] lh, input logic [1:0] lm,
                      input logic [1:0] lp, input string tag);
    bit e_hit, e_dup, e_ok, e_full, e_err;
    int e_base, e_idx;
    e_hit = 0; e_base = 0; e_dup = 0; e_ok = 0; e_full = 0; e_idx = -1; e_err = 0;
    for (int i = 0; i < N; i++)
      if (mst[i] == 2 && mh[i] == lh && mm[i] == lm && mp[i] == lp) begin
        e_hit = 1; e_base = int'(mb[i]);
      end
    for (int i = 0; i < N; i++)
      if (mst[i] != 0 && mh[i] == ah && mm[i] == am) e_dup = 1;
    if (!e_dup) begin
      for (int i = N - 1; i >= 0; i--) if (mst[i] != 0 && mm[i] != am) e_idx = i;
      for (int i = N - 1; i >= 0; i--) if (mst[i] == 0) e_idx = i;
    end
    e_ok = !e_dup && (e_idx >= 0);
    e_full = !e_dup && (e_idx < 0);
    e_err = (mst[di] != 1);
    alloc_valid = av; alloc_hash = ah; alloc_model = am; alloc_part = ap; alloc_base = ab;
    done_valid = dv; done_idx = di;
    lkp_valid = lv; lkp_hash = lh; lkp_model = lm; lkp_part = lp;
    @(posedge clk);
    if (dv && !e_err) mst[di] = 2;
    if (av && e_ok) begin
      mst[e_idx] = 1; mh[e_idx] = ah; mm[e_idx] = am; mp[e_idx] = ap; mb[e_idx] = ab;
    end
    @(negedge clk);
    if (lv) begin
      check(tag, "lkp_hit", int'(lkp_hit), int'(e_hit));
      check(tag, "lkp_miss", int'(lkp_miss), int'(!e_hit));
      if (e_hit) check(tag, "lkp_base", int'(lkp_base), e_base);
    end
    if (av) begin
      check(tag, "alloc_ok", int'(alloc_ok), int'(e_ok));
      check(tag, "alloc_dup", int'(alloc_dup), int'(e_dup));
      check(tag, "alloc_full", int'(alloc_full), int'(e_full));
      if (e_ok) check(tag, "alloc_idx", int'(alloc_idx), e_idx);
    end
    if (dv) check(tag, "done_err", int'(done_err), int'(e_err));
    alloc_valid = 0; done_valid = 0; lkp_valid = 0;
  endtask

  task automatic lookup(input logic [7:0] h, input logic [1:0] m, input logic [1:0] p,
                        input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, h, m, p, tag);
  endtask

  task automatic alloc(input logic [7:0] h, input logic [1:0] m, input logic [1:0] p,
                       input logic [7:0] b, input string tag);
    step(1, h, m, p, b, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic done(input logic [1:0] i, input string tag);
    step(0, 0, 0, 0, 0, 1, i, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mst[i] = 0; mh[i] = 0; mm[i] = 0; mp[i] = 0; mb[i] = 0; end
    alloc_valid = 0; done_valid = 0; lkp_valid = 0;
    alloc_hash = 0; alloc_model = 0; alloc_part = 0; alloc_base = 0; done_idx = 0;
    lkp_hash = 0; lkp_model = 0; lkp_part = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R13: reset state
    check("R13", "lkp_hit", int'(lkp_hit), 0);
    check("R13", "alloc_ok", int'(alloc_ok), 0);
    check("R13", "done_err", int'(done_err), 0);
    lookup(8'd10, 2'd1, 2'd0, "R13");

    // R7: fill entries 0..3 in index order, partitions alternate
    for (int i = 0; i < N; i++)
      alloc(8'(10 + i), 2'd1, 2'(i % 2), 8'(8'h40 + i), "R7");
    // R2: blocks being written stay hidden
    for (int i = 0; i < N; i++) lookup(8'(10 + i), 2'd1, 2'(i % 2), "R2");
    // R3: hint with a lookup of the same block in the same cycle misses, next cycle hits
    for (int i = 0; i < N; i++) begin
      step(0, 0, 0, 0, 0, 1, 2'(i), 1, 8'(10 + i), 2'd1, 2'(i % 2), "R3");
      lookup(8'(10 + i), 2'd1, 2'(i % 2), "R3");
    end
    // R1 R5 R6: sweep every hash, model and partition combination
    for (int h = 9; h <= 14; h++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 4; p++)
          lookup(8'(h), 2'(m), 2'(p), (m != 1) ? "R5" : ((p != (h % 2)) ? "R6" : "R1"));

    // R9: duplicate hash and version, from another partition too
    alloc(8'd10, 2'd1, 2'd3, 8'h99, "R9");
    lookup(8'd10, 2'd1, 2'd0, "R9");
    // R10: table full with current-version entries
    alloc(8'd20, 2'd1, 2'd0, 8'h77, "R10");
    for (int i = 0; i < N; i++) lookup(8'(10 + i), 2'd1, 2'(i % 2), "R10");
    // R11 / R4: hint on a shared entry is rejected, entry unchanged
    done(2'd0, "R11");
    lookup(8'd10, 2'd1, 2'd0, "R4");
    // R8: new version reclaims lowest stale entry (0)
    alloc(8'd30, 2'd2, 2'd1, 8'h50, "R8");
    lookup(8'd10, 2'd1, 2'd0, "R8");
    done(2'd0, "R3");
    done(2'd0, "R11");
    lookup(8'd30, 2'd2, 2'd1, "R3");
    // R12: reclaiming allocate and lookup of the displaced block in one cycle
    step(1, 8'd50, 2'd2, 2'd0, 8'h60, 0, 0, 1, 8'd11, 2'd1, 2'd1, "R12");
    lookup(8'd11, 2'd1, 2'd1, "R12");
    // R9: duplicate of a WRITING entry of the same version
    alloc(8'd50, 2'd2, 2'd2, 8'h61, "R9");
    // R12: allocate and lookup of the same new hash in one cycle
    step(1, 8'd60, 2'd2, 2'd0, 8'h70, 0, 0, 1, 8'd60, 2'd2, 2'd0, "R12");
    lookup(8'd60, 2'd2, 2'd0, "R2");
    // R8: remaining stale entry then full for version 2
    alloc(8'd70, 2'd2, 2'd0, 8'h71, "R8");
    alloc(8'd80, 2'd2, 2'd0, 8'h72, "R10");
    for (int i = 0; i < N; i++) done(2'(i), "R11");
    for (int h = 30; h <= 80; h += 10)
      for (int p = 0; p < 2; p++) lookup(8'(h), 2'd2, 2'(p), "R1");

    finish_run();
  end
endmodule